// File: doc/BRIEF.md
# Trimmed Pulse-Width DAC Generator

This block produces a single-bit pulse train meant to drive an external low-pass filter as a coarse digital-to-analog converter. A 6-bit duty word sets the base high time, in clock ticks, inside a fixed period of 64 ticks. Periods are grouped into repeating frames of 16. A 4-bit trim word adds one extra tick of high time to a chosen subset of the periods in each frame. Averaged over a frame, this gives sixteen fine steps between two adjacent duty settings.

The trim bits are weighted like a binary rate multiplier. The most significant trim bit widens half of the periods. Each lower bit widens half as many periods as the bit above it, and the periods it picks are spread evenly across the frame. A polarity input inverts the whole waveform. With zero duty and zero trim, that turns the output into a constant level, so the pin can serve as a static output. Duty, trim and polarity are captured once per frame, just before period 0, so that a frame is never a mix of old and new settings.

Top module: `pwm_trim`

## Requirements
- R1: A period is exactly 64 clock ticks. With no extra tick, the active level lasts for as many ticks as the duty word. It is one contiguous run that starts at tick 0 of the period.
- R2: Periods are numbered 0 to 15 within a frame. Each trim bit selects a set of periods, and the sets of the set bits add together. Trim bit 3 selects the odd periods. Bit 2 selects periods 2, 6, 10 and 14. Bit 1 selects periods 4 and 12. Bit 0 selects period 8. Period 0 is never selected.
- R3: A selected period gets one extra active tick, placed at the start of the pulse. Its pulse covers ticks 0 through duty+extra-1.
- R4: With duty 0x18 and trim 0x6, the pulse is 25 ticks wide in periods 2, 4, 6, 10, 12 and 14, and 24 ticks wide in every other period.
- R5: With duty 0 and trim 0 and normal polarity, the output stays at 0 for the whole frame.
- R6: With duty 0x3F and trim 0xF, the output is active for all 64 ticks of periods 1 to 15. In period 0 it is inactive only at tick 63.
- R7: Polarity 1 inverts the output. With duty 0 and trim 0, polarity 1 gives a constant 1.
- R8: Duty, trim and polarity are sampled only at the end of period 15. A change made inside a frame takes effect at period 0 of the next frame.
- R9: While reset is high, the output equals the polarity input and the settings are captured from the inputs. After release, the first output value is the one for tick 0 of period 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | 6 | Base pulse width in ticks |
| trim_i | input | 4 | Rate-multiplier trim word |
| pol_i | input | 1 | Output inversion, 1 = inverted |
| pw_o | output | 1 | Registered pulse output |

## Verification
The output is registered, so the level for tick k of a period appears one edge after the tick counter holds k. The first sample taken at the falling edge after reset release is therefore tick 0 of period 0. From there, each run of 64 consecutive falling-edge samples is one period. The bench compares every sample against a pattern it builds from the duty, the trim table and the polarity, and reports one check per period. Settings changed inside a frame are expected to take effect from the first sample of the next frame's period 0, and the bench keeps the old pattern until that sample.

// File: rtl/pwm_trim.sv
module pwm_trim #(
  parameter int DUTY_W = 6,
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              pol_i,
  output logic              pw_o
);
  localparam int WID_W = DUTY_W + 1;

  logic [DUTY_W-1:0] tick;
  logic [TRIM_W-1:0] period;
  logic [DUTY_W-1:0] duty_q;
  logic [TRIM_W-1:0] trim_q;
  logic              pol_q;
  logic [TRIM_W-1:0] sel;
  logic              pw_q;

  wire frame_end = (&tick) & (&period);

  // trim bit k picks periods whose lowest set bit sits at TRIM_W-1-k
  for (genvar k = 0; k < TRIM_W; k++) begin : g_sel
    localparam int J = TRIM_W - 1 - k;
    assign sel[k] = trim_q[k] & period[J] & ~|(period & TRIM_W'((1 << J) - 1));
  end

  wire             extra  = |sel;
  wire [WID_W-1:0] width  = {1'b0, duty_q} + WID_W'(extra);
  wire             active = {1'b0, tick} < width;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick   <= '0;
      period <= '0;
      duty_q <= duty_i;
      trim_q <= trim_i;
      pol_q  <= pol_i;
      pw_q   <= pol_i;
    end else begin
      tick <= tick + 1'b1;
      if (&tick) period <= period + 1'b1;
      if (frame_end) begin
        duty_q <= duty_i;
        trim_q <= trim_i;
        pol_q  <= pol_i;
      end
      pw_q <= active ^ pol_q;
    end
  end

  assign pw_o = pw_q;
endmodule

// File: rtl/pwm_trim_chk.sv
module pwm_trim_chk #(
  parameter int DUTY_W = 6,
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              pol_i,
  input logic [DUTY_W-1:0] tick,
  input logic [TRIM_W-1:0] period,
  input logic [DUTY_W-1:0] duty_q,
  input logic [TRIM_W-1:0] trim_q,
  input logic              pol_q,
  input logic              pw_o
);
  assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (&tick) |=> (tick == '0));

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst)
    !(&tick) |=> (tick == $past(tick) + 1'b1));

  assert_period_step_R2: assert property (@(posedge clk) disable iff (rst)
    (&tick) |=> (period == $past(period) + 1'b1));

  assert_first_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (tick == '0 && duty_q != '0) |=> (pw_o != $past(pol_q)));

  assert_zero_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0 && trim_q == '0) |=> (pw_o == $past(pol_q)));

  assert_full_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ((&duty_q) && (&tick) && period == '0) |=> (pw_o == $past(pol_q)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !((&tick) && (&period)) |=> ($stable(duty_q) && $stable(trim_q) && $stable(pol_q)));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (pw_o == $past(pol_i) && tick == '0 && period == '0));
endmodule

bind pwm_trim pwm_trim_chk #(.DUTY_W(DUTY_W), .TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst(rst), .pol_i(pol_i), .tick(tick), .period(period),
  .duty_q(duty_q), .trim_q(trim_q), .pol_q(pol_q), .pw_o(pw_o)
);

// File: tb/pwm_trim_bench.sv
module pwm_trim_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] duty_i = '0;
  logic [3:0] trim_i = '0;
  logic       pol_i = 1'b0;
  logic       pw_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  pwm_trim u_pwm_trim (
    .clk(clk), .rst(rst), .duty_i(duty_i), .trim_i(trim_i), .pol_i(pol_i), .pw_o(pw_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // R2 trim table, written from the requirement
  function automatic bit exp_extra(input logic [3:0] tr, input int p);
    return (tr[3] && (p % 2 == 1)) || (tr[2] && (p % 4 == 2)) ||
           (tr[1] && (p % 8 == 4)) || (tr[0] && p == 8);
  endfunction

  task automatic do_reset(input logic [5:0] d, input logic [3:0] tr, input logic pl);
    @(negedge clk);
    rst = 1'b1; duty_i = d; trim_i = tr; pol_i = pl;
    repeat (3) @(negedge clk);
    tests++;
    if (pw_o !== pl) begin
      fails++;
      $display("FAIL R9 reset level: got %b expected %b", pw_o, pl);
    end
    rst = 1'b0;
  endtask

  // one period: 64 falling-edge samples, first one is tick 0
  task automatic check_period(input int p, input logic [5:0] d, input logic [3:0] tr,
                              input logic pl, input string tag);
    int w = int'(d) + (exp_extra(tr, p) ? 1 : 0);
    int bad = 0;
    int first_t = -1;
    logic got_b = 1'b0;
    logic exp_b = 1'b0;
    for (int t = 0; t < 64; t++) begin
      logic e;
      @(negedge clk);
      e = (t < w) ^ pl;
      if (pw_o !== e) begin
        bad++;
        if (first_t < 0) begin first_t = t; got_b = pw_o; exp_b = e; end
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s period %0d tick %0d: got %b expected %b (width %0d)",
               tag, p, first_t, got_b, exp_b, w);
    end
  endtask

  task automatic check_frame(input logic [5:0] d, input logic [3:0] tr,
                             input logic pl, input string tag);
    for (int p = 0; p < 16; p++) check_period(p, d, tr, pl, tag);
  endtask

  task automatic t_base_R1;
    do_reset(6'd24, 4'h0, 1'b0);
    check_frame(6'd24, 4'h0, 1'b0, "R1");
  endtask

  task automatic t_example_R4;
    do_reset(6'h18, 4'h6, 1'b0);
    check_frame(6'h18, 4'h6, 1'b0, "R4");
  endtask

  task automatic t_bits_R2;
    for (int b = 0; b < 4; b++) begin
      do_reset(6'd5, 4'(1 << b), 1'b0);
      check_frame(6'd5, 4'(1 << b), 1'b0, "R2");
    end
    do_reset(6'd0, 4'hF, 1'b0);
    check_frame(6'd0, 4'hF, 1'b0, "R3");
  endtask

  task automatic t_zero_R5;
    do_reset(6'd0, 4'h0, 1'b0);
    check_frame(6'd0, 4'h0, 1'b0, "R5");
  endtask

  task automatic t_full_R6;
    do_reset(6'h3F, 4'hF, 1'b0);
    check_frame(6'h3F, 4'hF, 1'b0, "R6");
  endtask

  task automatic t_pol_R7;
    do_reset(6'd0, 4'h0, 1'b1);
    check_frame(6'd0, 4'h0, 1'b1, "R7");
    do_reset(6'h18, 4'h6, 1'b1);
    check_frame(6'h18, 4'h6, 1'b1, "R7");
  endtask

  task automatic t_sample_R8;
    do_reset(6'd10, 4'h0, 1'b0);
    for (int p = 0; p < 5; p++) check_period(p, 6'd10, 4'h0, 1'b0, "R8");
    duty_i = 6'd40; trim_i = 4'h9; pol_i = 1'b1;
    for (int p = 5; p < 16; p++) check_period(p, 6'd10, 4'h0, 1'b0, "R8");
    check_frame(6'd40, 4'h9, 1'b1, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_base_R1();
    t_example_R4();
    t_bits_R2();
    t_zero_R5();
    t_full_R6();
    t_pol_R7();
    t_sample_R8();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule